// File: doc/BRIEF.md
# Armed Low-Interval Meter

This block times how long an external activity line spends at logic low. Software or a
sequencer arms it. The block then waits for the line to fall. From that falling edge it
counts elapsed time in units of a fixed number of prescale ticks. It stops on the next
rising edge, shows the result on its count output and marks the end of the measurement
with a single-cycle done pulse.

The line is asynchronous to the block's clock, so it first passes through a
synchronizer. The count is held in a chain of byte-wide stages, and each stage carries
into the next. If the interval is longer than the whole chain can hold, the block stops
counting and raises an "interval too long" flag instead of giving a result. Each arm
yields at most one measurement.

Top module: `lowtime_meter`

## Requirements
- R1: After reset, `countOut`, `doneOut` and `overflowOut` are all zero.
- R2: Once a result has been reported, further low pulses on `gateIn` produce no done pulse and leave `countOut` unchanged until `armIn` is pulsed again.
- R3: Only a high-to-low transition of `gateIn` seen after arming starts a measurement. If the line is already low when the block is armed, its later rise ends nothing and gives no done pulse.
- R4: With `tickIn` held high and `gateIn` low for L clock cycles, the reported count is floor(L / TICKS_PER_COUNT), which is floor(L/16) by default.
- R5: When `tickIn` is not always high, only cycles with `tickIn` high advance time. The counted window is L cycles long and starts three cycles after the first cycle in which `gateIn` is low. The count equals floor(T / TICKS_PER_COUNT), where T is the number of high `tickIn` cycles in that window.
- R6: The count is a plain binary number made of NUM_BYTES stages of BYTE_W bits, with the lowest stage in the least significant bits. A stage advances exactly when every stage below it wraps from all ones to zero.
- R7: When the top stage would wrap past all ones, counting stops. In the same cycle `overflowOut` goes high, `doneOut` pulses and `countOut` reads zero.
- R8: `doneOut` is high for exactly one cycle per measurement. From that cycle on, `countOut` stays frozen until the next arm.
- R9: A pulse on `armIn` while a measurement is counting has no effect on the result.
- R10: `overflowOut` stays high until the next arm. The arm clears both the flag and the count.
- R11: `doneOut` goes high on the third rising clock edge, counting the first edge that samples `gateIn` high after the low interval as edge one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| gateIn | input | 1 | Asynchronous activity line; its low time is measured |
| tickIn | input | 1 | Prescale tick; time advances only in cycles where it is high |
| armIn | input | 1 | Arm request: clears the result and waits for a falling edge |
| countOut | output | NUM_BYTES*BYTE_W | Measured interval in units of TICKS_PER_COUNT ticks |
| doneOut | output | 1 | One-cycle pulse when a measurement ends, normally or on overflow |
| overflowOut | output | 1 | Interval too long; held until the next arm |

## Verification
A table of low intervals is run with `tickIn` held high. The lengths cover values below
one count unit, exact multiples of a unit, and lengths that carry into the second and
third stages. This separates off-by-one errors in the window from broken carries between
stages. The same pulses are then run with `tickIn` active on every second cycle, every
third cycle, or never, which shows whether the prescaler advances on ticks or on clocks.
The largest count that still fits is checked against an interval one unit longer, so
overflow detection cannot trigger early or late. Directed runs cover an arm while
counting, a low pulse with no arm, and arming while the line is already low; these tell
true edge starts apart from level starts.

// File: rtl/lowtime_meter_pkg.sv
package lowtime_meter_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } meterState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;  // zero prescaler and every count stage
    logic tickRun;   // one prescale tick inside an active measurement
  } meterStrobe_t;

endpackage

// File: rtl/lowtime_meter_ctrl.sv
module lowtime_meter_ctrl
  import lowtime_meter_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         gateIn,
  input  logic         tickIn,
  input  logic         armIn,
  input  logic         topWrap,
  output meterStrobe_t strobe,
  output logic         doneOut,
  output logic         overflowOut
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   gateSync;
  logic                   gatePrev;
  logic                   fallSeen;
  logic                   riseSeen;
  logic                   armTake;
  logic                   endNow;
  meterState_e            stateQ;
  meterState_e            stateD;

  // idle level of the line is high: reset the chain to ones
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ    <= '1;
      gatePrev <= 1'b1;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], gateIn};
      gatePrev <= gateSync;
    end
  end

  assign gateSync = syncQ[SYNC_STAGES-1];
  assign fallSeen = gatePrev & ~gateSync;
  assign riseSeen = ~gatePrev & gateSync;

  assign armTake = armIn && (stateQ != ST_RUN);
  assign endNow  = (stateQ == ST_RUN) && (riseSeen || topWrap);

  always_comb begin
    stateD = stateQ;
    if (armTake) begin
      stateD = ST_WAIT;
    end else begin
      case (stateQ)
        ST_WAIT: if (fallSeen) stateD = ST_RUN;
        ST_RUN:  if (endNow)   stateD = ST_IDLE;
        default: stateD = stateQ;
      endcase
    end
  end

  always_comb begin
    strobe.clearAll = armTake || ((stateQ == ST_WAIT) && fallSeen);
    strobe.tickRun  = (stateQ == ST_RUN) && tickIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ      <= ST_IDLE;
      doneOut     <= 1'b0;
      overflowOut <= 1'b0;
    end else begin
      stateQ  <= stateD;
      doneOut <= endNow;
      if (armTake) begin
        overflowOut <= 1'b0;
      end else if ((stateQ == ST_RUN) && topWrap) begin
        overflowOut <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lowtime_meter_dp.sv
module lowtime_meter_dp
  import lowtime_meter_pkg::*;
#(
  parameter int TICKS_PER_COUNT = 16,
  parameter int BYTE_W          = 8,
  parameter int NUM_BYTES       = 3,
  localparam int CNT_W          = BYTE_W * NUM_BYTES,
  localparam int PRE_W          = (TICKS_PER_COUNT > 1) ? $clog2(TICKS_PER_COUNT) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  meterStrobe_t     strobe,
  output logic [CNT_W-1:0] countOut,
  output logic             topWrap
);

  logic [PRE_W-1:0]   preQ;
  logic               preLast;
  logic [NUM_BYTES:0] carry;

  assign preLast = (preQ == PRE_W'(TICKS_PER_COUNT - 1));

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearAll) begin
      preQ <= '0;
    end else if (strobe.tickRun) begin
      preQ <= preLast ? '0 : preQ + 1'b1;
    end
  end

  assign carry[0] = strobe.tickRun && preLast;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : gStage
    logic [BYTE_W-1:0] byteQ;

    always_ff @(posedge clk) begin
      if (!rstN || strobe.clearAll) begin
        byteQ <= '0;
      end else if (carry[g]) begin
        byteQ <= byteQ + 1'b1;
      end
    end

    assign carry[g+1]                   = carry[g] && (&byteQ);
    assign countOut[g*BYTE_W +: BYTE_W] = byteQ;
  end

  assign topWrap = carry[NUM_BYTES];

endmodule

// File: rtl/lowtime_meter.sv
module lowtime_meter
  import lowtime_meter_pkg::*;
#(
  parameter int TICKS_PER_COUNT = 16,
  parameter int BYTE_W          = 8,
  parameter int NUM_BYTES       = 3,
  parameter int SYNC_STAGES     = 2,
  localparam int CNT_W          = BYTE_W * NUM_BYTES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             gateIn,
  input  logic             tickIn,
  input  logic             armIn,
  output logic [CNT_W-1:0] countOut,
  output logic             doneOut,
  output logic             overflowOut
);

  meterStrobe_t strobe;
  logic         topWrap;

  lowtime_meter_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .gateIn     (gateIn),
    .tickIn     (tickIn),
    .armIn      (armIn),
    .topWrap    (topWrap),
    .strobe     (strobe),
    .doneOut    (doneOut),
    .overflowOut(overflowOut)
  );

  lowtime_meter_dp #(
    .TICKS_PER_COUNT(TICKS_PER_COUNT),
    .BYTE_W         (BYTE_W),
    .NUM_BYTES      (NUM_BYTES)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .countOut(countOut),
    .topWrap (topWrap)
  );

endmodule

// File: rtl/lowtime_meter_chk.sv
module lowtime_meter_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             armIn,
  input logic [CNT_W-1:0] countOut,
  input logic             doneOut,
  input logic             overflowOut
);

  // set by a done pulse, cleared by any arm request
  logic finQ;
  always_ff @(posedge clk) begin
    if (!rstN)        finQ <= 1'b0;
    else if (armIn)   finQ <= 1'b0;
    else if (doneOut) finQ <= 1'b1;
  end

  // R8: done lasts a single cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R8: result frozen after done until an arm arrives
  a_r8_result_frozen: assert property (@(posedge clk) disable iff (!rstN)
    ((finQ || doneOut) && !armIn) |=> $stable(countOut));

  // R7: overflow appears together with done and a zero count
  a_r7_overflow_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflowOut) |-> (doneOut && (countOut == '0)));

  // R10: overflow flag held while no arm arrives
  a_r10_overflow_held: assert property (@(posedge clk) disable iff (!rstN)
    (overflowOut && !armIn) |=> overflowOut);

  // R6: the count only holds, steps by one, or returns to zero
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((countOut == $past(countOut)) ||
              (countOut == CNT_W'($past(countOut) + 1'b1)) ||
              (countOut == '0)));

endmodule

bind lowtime_meter lowtime_meter_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .armIn      (armIn),
  .countOut   (countOut),
  .doneOut    (doneOut),
  .overflowOut(overflowOut)
);

// File: tb/lowtime_meter_tb_top.sv
`timescale 1ns/1ps
module lowtime_meter_tb_top;

  localparam int TPC   = 16;
  localparam int BW    = 3;
  localparam int NB    = 3;
  localparam int CW    = BW * NB;
  localparam int MAXC  = (1 << CW) - 1;
  localparam int VEC_N = 9;

  // stimulus vectors: low length, tick mode (0 all, 1 even, 2 every third, 3 none), tag
  localparam int vecLen  [VEC_N] = '{5, 16, 47, 130, 1030, 100, 200, 300, 8191};
  localparam int vecMode [VEC_N] = '{0,  0,  0,   0,    0,   1,   2,   3,    0};
  localparam int vecTag  [VEC_N] = '{4,  4,  4,   6,    6,   5,   5,   5,    4};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          gateIn = 1'b1;
  logic          tickIn = 1'b1;
  logic          armIn = 1'b0;
  logic [CW-1:0] countOut;
  logic          doneOut;
  logic          overflowOut;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  lowtime_meter #(
    .TICKS_PER_COUNT(TPC),
    .BYTE_W         (BW),
    .NUM_BYTES      (NB)
  ) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .gateIn     (gateIn),
    .tickIn     (tickIn),
    .armIn      (armIn),
    .countOut   (countOut),
    .doneOut    (doneOut),
    .overflowOut(overflowOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pat(input int mode, input int i);
    case (mode)
      0: return 1'b1;
      1: return (i % 2) == 0;
      2: return (i % 3) == 0;
      default: return 1'b0;
    endcase
  endfunction

  // ticks in the counted window: cycles 3 .. len+2 after the first low cycle
  function automatic int expTicks(input int len, input int mode);
    int t = 0;
    for (int i = 3; i <= len + 2; i++) t += pat(mode, i);
    return t;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doArm();
    armIn = 1'b1;
    @(negedge clk);
    armIn = 1'b0;
    idle(3);
  endtask

  task automatic measure(input int len, input int mode, input int armAt, input string req);
    int exp;
    bit early = 1'b0;
    int held;
    exp = expTicks(len, mode) / TPC;
    for (int i = 0; i <= len + 2; i++) begin
      gateIn = (i < len) ? 1'b0 : 1'b1;
      tickIn = pat(mode, i);
      armIn  = (i == armAt);
      @(negedge clk);
      if (i < len + 2 && doneOut) early = 1'b1;
    end
    armIn  = 1'b0;
    tickIn = 1'b1;
    check(!early, "R11 done not early", int'(early), 0);
    check(doneOut == 1'b1, "R11 done on third edge", int'(doneOut), 1);
    check(int'(countOut) == exp, req, int'(countOut), exp);
    check(overflowOut == 1'b0, {req, " no overflow"}, int'(overflowOut), 0);
    held = int'(countOut);
    @(negedge clk);
    check(doneOut == 1'b0, "R8 done one cycle", int'(doneOut), 0);
    idle(5);
    check(int'(countOut) == held, "R8 count frozen", int'(countOut), held);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin : main
    int held;
    bit seen;
    idle(4);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(countOut == '0, "R1 count", int'(countOut), 0);
    check(doneOut == 1'b0, "R1 done", int'(doneOut), 0);
    check(overflowOut == 1'b0, "R1 overflow", int'(overflowOut), 0);

    // vector table: R4, R5, R6
    for (int v = 0; v < VEC_N; v++) begin
      doArm();
      measure(vecLen[v], vecMode[v], -1, $sformatf("R%0d vector %0d", vecTag[v], v));
      idle(4);
    end

    // R9 arm while counting is ignored
    doArm();
    measure(96, 0, 40, "R9 arm during count");

    // R2 low pulse without a fresh arm
    held = int'(countOut);
    seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      gateIn = (i < 40) ? 1'b0 : 1'b1;
      @(negedge clk);
      if (doneOut) seen = 1'b1;
    end
    check(!seen, "R2 no done without arm", int'(seen), 0);
    check(int'(countOut) == held, "R2 count unchanged", int'(countOut), held);

    // R7 overflow: the tick that would pass MAXC arrives at loop index 3 + (MAXC+1)*TPC - 1
    doArm();
    seen = 1'b0;
    for (int i = 0; i <= 2 + (MAXC + 1) * TPC; i++) begin
      gateIn = 1'b0;
      @(negedge clk);
      if (i < 2 + (MAXC + 1) * TPC && doneOut) seen = 1'b1;
    end
    check(!seen, "R7 no early done", int'(seen), 0);
    check(doneOut == 1'b1, "R7 done at wrap", int'(doneOut), 1);
    check(overflowOut == 1'b1, "R7 overflow set", int'(overflowOut), 1);
    check(countOut == '0, "R7 count zero", int'(countOut), 0);
    seen = 1'b0;
    for (int i = 0; i < 10; i++) begin
      gateIn = (i < 3) ? 1'b0 : 1'b1;
      @(negedge clk);
      if (doneOut && i > 0) seen = 1'b1;
    end
    check(!seen, "R10 no done after overflow", int'(seen), 0);
    check(overflowOut == 1'b1, "R10 overflow held", int'(overflowOut), 1);

    // R3 arm while line already low; R10 arm clears overflow
    gateIn = 1'b0;
    idle(10);
    armIn = 1'b1;
    @(negedge clk);
    armIn = 1'b0;
    check(overflowOut == 1'b0, "R10 arm clears overflow", int'(overflowOut), 0);
    check(countOut == '0, "R10 arm clears count", int'(countOut), 0);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      gateIn = (i < 10) ? 1'b0 : 1'b1;
      @(negedge clk);
      if (doneOut) seen = 1'b1;
    end
    check(!seen, "R3 rise without fall ignored", int'(seen), 0);
    measure(64, 0, -1, "R3 later fall starts");

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule